// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A caller loads a table root address, the virtual address and the kind of access (write or read, user or supervisor), then pulses `start`. The walker makes one memory read for the first-level entry. If that entry is valid, it makes a second read for the leaf entry. It then reports the physical address, a page fault or a protection fault, and marks the result with a single-cycle `done`.

Pages are 4 KB. The top ten bits of the virtual address select one of 1024 first-level entries, and the next ten bits select one of 1024 leaf entries. Each entry is 32 bits and sits at its table base plus four times its index. In every entry, bits [31:12] hold a frame number, bit 0 means present, bit 1 allows writes and bit 2 allows user-mode access. A valid first-level entry gives the leaf table base as its frame number followed by twelve zero bits.

Memory traffic uses two valid/ready channels. A request holds its valid and address until ready is sampled high, so the memory may stall it for any number of cycles. The response ready is high only while the walker is waiting for data, and the memory may take any number of cycles to answer.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `mem_req_valid` and `mem_rsp_ready` are low, and the walker accepts `start`.
- R2: The first read address is `ptbr + va[31:22]*4`, taken from the values present in the `start` cycle.
- R3: The second read address is `{first_entry[31:12], 12'h000} + va[21:12]*4`.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.
- R5: `mem_rsp_ready` is high while a read is outstanding. Response data is taken in the first cycle in which `mem_rsp_valid` is high, however late that cycle comes.
- R6: When a walk succeeds, `pa` is `{leaf[31:12], va[11:0]}` and both fault flags are low.
- R7: A first-level entry with bit 0 clear gives `page_fault`, with no second read.
- R8: A leaf entry with bit 0 clear gives `page_fault`, whatever its rights bits hold.
- R9: A present leaf gives `prot_fault` when a write meets a clear bit 1 or a user access meets a clear bit 2. The two fault flags never assert together, and `pa` is zero on any fault.
- R10: `done` is high for exactly one cycle per accepted walk. `pa` and the fault flags are valid in that cycle.
- R11: `start` is ignored while a walk is in progress. It does not change the running walk and does not queue another.
- R12: Bits 1 and 2 of the first-level entry have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ptbr | input | 32 | Byte address of the first-level table |
| va | input | 32 | Virtual address to translate |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_user | input | 1 | 1 = user-mode access |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker can take read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Translated physical address |
| page_fault | output | 1 | Entry not present |
| prot_fault | output | 1 | Access rights violated |

## Verification
The bench stalls both the request and the response channels by several cycles. A walker that let its address move during a stall, or that sampled stale response data, would fetch the wrong entry. It checks that a missing first-level entry stops after one read, and that a leaf with rights bits set but the present bit clear gives a page fault rather than a protection fault. It also checks that the first-level rights bits are ignored, and that offset 0xFFF passes straight through. It pulses `start` again during a walk; a design that restarted or queued a walk would show a changed address or an unexpected second `done`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_WRITE_BIT   = 1;
  localparam int PTE_USER_BIT    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW    = 32,
  parameter int IDX_W = 10
) (
  input  logic [AW-1:0]    table_base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    entry_addr
);
  localparam int PAD_W = AW - IDX_W - 2;

  assign entry_addr = table_base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check #(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic             is_user,
  output logic             pg_fault,
  output logic             rights_fault
);
  import ptw_pkg::*;

  logic denied;
  assign denied       = (is_write && !pte[PTE_WRITE_BIT]) || (is_user && !pte[PTE_USER_BIT]);
  assign pg_fault     = !pte[PTE_PRESENT_BIT];
  assign rights_fault = pte[PTE_PRESENT_BIT] && denied;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTE_W-1:0] ptbr,
  input  logic [VA_W-1:0]  va,
  input  logic             acc_write,
  input  logic             acc_user,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PTE_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PTE_W-1:0] pa,
  output logic             page_fault,
  output logic             prot_fault
);
  import ptw_pkg::*;

  localparam int FRAME_W = PTE_W - OFF_W;
  localparam int LEVELS  = 2;

  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [PTE_W-1:0] root_q, leaf_base_q, pa_q;
  logic             wr_q, usr_q, pf_q, prot_q;

  logic [PTE_W-1:0] tbase [LEVELS];
  logic [IDX_W-1:0] tidx  [LEVELS];
  logic [PTE_W-1:0] eaddr [LEVELS];

  assign tbase[0] = root_q;
  assign tbase[1] = leaf_base_q;
  assign tidx[0]  = va_q[VA_W-1 -: IDX_W];
  assign tidx[1]  = va_q[OFF_W +: IDX_W];

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    ptw_addr_gen #(.AW(PTE_W), .IDX_W(IDX_W)) u_ag (
      .table_base (tbase[g]),
      .idx        (tidx[g]),
      .entry_addr (eaddr[g])
    );
  end

  logic leaf_pf, leaf_prot;
  ptw_leaf_check #(.PTE_W(PTE_W)) u_chk (
    .pte          (mem_rsp_data),
    .is_write     (wr_q),
    .is_user      (usr_q),
    .pg_fault     (leaf_pf),
    .rights_fault (leaf_prot)
  );

  logic unused_pte_bits;
  assign unused_pte_bits = ^mem_rsp_data[OFF_W-1:PTE_USER_BIT+1];

  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr  = (state_q == ST_L2_REQ) ? eaddr[1] : eaddr[0];
  assign mem_rsp_ready = (state_q == ST_L1_WAIT) || (state_q == ST_L2_WAIT);
  assign done          = (state_q == ST_DONE);
  assign pa            = pa_q;
  assign page_fault    = pf_q;
  assign prot_fault    = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      root_q      <= '0;
      leaf_base_q <= '0;
      pa_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      pf_q        <= 1'b0;
      prot_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          va_q    <= va;
          root_q  <= ptbr;
          wr_q    <= acc_write;
          usr_q   <= acc_user;
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[PTE_PRESENT_BIT]) begin
            pf_q    <= 1'b1;
            prot_q  <= 1'b0;
            pa_q    <= '0;
            state_q <= ST_DONE;
          end else begin
            leaf_base_q <= {mem_rsp_data[PTE_W-1 -: FRAME_W], {OFF_W{1'b0}}};
            state_q     <= ST_L2_REQ;
          end
        end
        ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          pf_q    <= leaf_pf;
          prot_q  <= leaf_prot;
          pa_q    <= (leaf_pf || leaf_prot) ? '0
                     : {mem_rsp_data[PTE_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(page_fault && prot_fault));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !page_fault && !prot_fault) |-> (pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> $stable(va_q));

  assert_l1_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_ready && !mem_req_valid && state_q == ST_L1_WAIT && mem_rsp_valid
     && !mem_rsp_data[PTE_PRESENT_BIT]) |=> (done && page_fault));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ptbr = '0;
  logic [31:0] va_in = '0;
  logic        acc_write = 1'b0;
  logic        acc_user = 1'b0;
  logic        mem_req_valid, mem_rsp_ready, done, page_fault, prot_fault;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, pa;
  logic [31:0] mem_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ptbr(ptbr), .va(va_in),
    .acc_write(acc_write), .acc_user(acc_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done(done), .pa(pa), .page_fault(page_fault), .prot_fault(prot_fault)
  );

  typedef struct {
    logic [31:0] pa;
    logic        pf;
    logic        prot;
    int          nf;
    logic [31:0] a1;
    logic [31:0] a2;
    string       tag;
  } exp_t;

  logic [31:0] mem [4096];
  exp_t        exp_q[$];
  logic [31:0] fetch_q[$];
  exp_t        cur;
  int          checks = 0;
  int          fails = 0;
  int          ready_dly = 0;
  int          rsp_dly = 0;
  int          walks_done = 0;
  logic [31:0] held;
  logic        prev_done = 1'b0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return (a < 32'h4000) ? mem[a[13:2]] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input int l1, input int l2, input int off);
    logic [9:0] i1 = l1[9:0];
    logic [9:0] i2 = l2[9:0];
    logic [11:0] o = off[11:0];
    return {i1, i2, o};
  endfunction

  // Memory responder: stalls the request channel, then answers after a delay.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        held = mem_req_addr;
        repeat (ready_dly) @(negedge clk);
        if (ready_dly > 0)
          check(mem_req_valid && mem_req_addr == held, "R4", "request held during stall",
                mem_req_addr, held);
        mem_req_ready = 1'b1;
        fetch_q.push_back(mem_req_addr);
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        if (rsp_dly > 0)
          check(mem_rsp_ready, "R5", "ready while waiting", {31'b0, mem_rsp_ready}, 32'h1);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(held);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hFFFF_FFFF;
      end
    end
  end

  // Monitor: pops the scoreboard on every completion.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done)
        check(1'b0, "R10", "done longer than one cycle", 32'h1, 32'h0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
        end else begin
          cur = exp_q.pop_front();
          check(pa == cur.pa && page_fault == cur.pf && prot_fault == cur.prot, cur.tag,
                "result {pf,prot,pa}", {page_fault, prot_fault, pa[29:0]},
                {cur.pf, cur.prot, cur.pa[29:0]});
          check(pa == cur.pa, cur.tag, "pa", pa, cur.pa);
          check(fetch_q.size() == cur.nf, (cur.nf == 1) ? "R7" : "R3", "read count",
                fetch_q.size(), cur.nf);
          if (fetch_q.size() >= 1)
            check(fetch_q[0] == cur.a1, "R2", "first read address", fetch_q[0], cur.a1);
          if (fetch_q.size() >= 2 && cur.nf == 2)
            check(fetch_q[1] == cur.a2, "R3", "second read address", fetch_q[1], cur.a2);
          fetch_q.delete();
        end
        walks_done++;
      end
    end
    prev_done = done;
  end

  task automatic walk(input logic [31:0] base, input logic [31:0] v, input bit wr,
                      input bit usr, input string tag, input bit poke);
    exp_t e;
    logic [31:0] ent1, ent2;
    int target;
    e.tag = tag; e.pf = 1'b0; e.prot = 1'b0; e.pa = '0; e.a2 = '0;
    e.a1 = base + {20'h0, v[31:22], 2'b00};
    ent1 = rd(e.a1);
    if (!ent1[0]) begin
      e.pf = 1'b1; e.nf = 1;
    end else begin
      e.nf = 2;
      e.a2 = {ent1[31:12], 12'h0} + {20'h0, v[21:12], 2'b00};
      ent2 = rd(e.a2);
      if (!ent2[0]) e.pf = 1'b1;
      else if ((wr && !ent2[1]) || (usr && !ent2[2])) e.prot = 1'b1;
      else e.pa = {ent2[31:12], v[11:0]};
    end
    exp_q.push_back(e);
    target = walks_done + 1;
    @(negedge clk);
    ptbr = base; va_in = v; acc_write = wr; acc_user = usr; start = 1'b1;
    @(negedge clk);
    start = 1'b0; va_in = ~v; ptbr = ~base; acc_write = ~wr; acc_user = ~usr;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; va_in = v ^ 32'h0040_0000;
      @(negedge clk);
      start = 1'b0;
    end
    wait (walks_done >= target);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
    report();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[0]      = 32'h0000_1001;
    mem[1]      = 32'h0000_2007;
    mem[2]      = 32'h0000_3000;
    mem[3]      = 32'h0000_2001;
    mem[12'hC00] = 32'h0000_2001;
    mem[12'h400] = 32'hABCD_E007;
    mem[12'h401] = 32'h1234_5001;
    mem[12'h402] = 32'h0000_0006;
    mem[12'h403] = 32'h5555_5003;
    mem[12'h7FF] = 32'hFFFF_F005;
    mem[12'h805] = 32'h0BEE_F007;
    mem[12'hBFF] = 32'h7777_7001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_req_valid && !mem_rsp_ready, "R1", "idle after reset",
          {29'b0, done, mem_req_valid, mem_rsp_ready}, 32'h0);

    ready_dly = 0; rsp_dly = 0;
    walk(32'h0, mkva(0, 0, 'h123), 1'b0, 1'b1, "R6", 1'b0);
    ready_dly = 3; rsp_dly = 2;
    walk(32'h0, mkva(0, 1, 'h456), 1'b0, 1'b0, "R4", 1'b0);
    ready_dly = 1; rsp_dly = 5;
    walk(32'h0, mkva(0, 1, 'h456), 1'b0, 1'b1, "R9", 1'b0);
    walk(32'h0, mkva(0, 3, 0), 1'b1, 1'b0, "R5", 1'b0);
    walk(32'h0, mkva(0, 3, 0), 1'b1, 1'b1, "R9", 1'b0);
    ready_dly = 0; rsp_dly = 1;
    walk(32'h0, mkva(0, 1023, 'hFFF), 1'b1, 1'b1, "R9", 1'b0);
    walk(32'h0, mkva(0, 1023, 'hFFF), 1'b0, 1'b1, "R6", 1'b0);
    walk(32'h0, mkva(0, 1, 0), 1'b1, 1'b0, "R9", 1'b0);
    walk(32'h0, mkva(2, 7, 0), 1'b0, 1'b0, "R7", 1'b0);
    walk(32'h0, mkva(1023, 0, 0), 1'b0, 1'b0, "R7", 1'b0);
    walk(32'h0, mkva(0, 2, 'h10), 1'b1, 1'b1, "R8", 1'b0);
    walk(32'h0, mkva(1, 5, 'h20), 1'b1, 1'b1, "R12", 1'b0);
    walk(32'h0, mkva(3, 5, 'h20), 1'b1, 1'b1, "R12", 1'b0);
    ready_dly = 2; rsp_dly = 0;
    walk(32'h3000, mkva(0, 1023, 'hABC), 1'b0, 1'b0, "R2", 1'b0);
    ready_dly = 0; rsp_dly = 0;
    walk(32'h0, mkva(0, 0, 'h7), 1'b1, 1'b1, "R11", 1'b1);

    repeat (12) @(negedge clk);
    check(!mem_req_valid && exp_q.size() == 0, "R11", "no walk queued by busy start",
          {31'b0, mem_req_valid}, 32'h0);
    report();
  end
endmodule